// File: doc/BRIEF.md
# SPI Flash Erase Command Sequencer

This block is a host-side SPI master that issues erase commands to a serial flash device. A client hands it one request over a valid/ready handshake. Each request gives the erase kind (single page or a block of eight pages), the page-size mode (standard or binary) and a 12-bit page number. The sequencer pulls chip select low and shifts out a 32-bit frame. The frame is an 8-bit opcode followed by a 24-bit address field, with the page bits placed according to the mode and zero padding around them. Chip select goes high again only after exactly 32 clocks, which starts the erase inside the flash. The sequencer then keeps chip select high for a guard time and waits for the device's busy input to drop. After that it pulses `done`.

The serial clock comes from the system clock through a divider, with a half period of `HALF_DIV` system cycles. SCK idles low, which suits SPI mode 0 and mode 3 devices. MOSI changes only after a falling SCK edge and holds steady across each rising edge.

The FSM has five states. `ST_IDLE` waits for a request and moves to `ST_SHIFT` when one is accepted. `ST_SHIFT` sends the 32 bits and moves to `ST_GAP` on the falling edge that ends the last bit. `ST_GAP` holds chip select high for `CS_GAP_SCK` SCK periods and then moves to `ST_WAIT`. `ST_WAIT` leaves for `ST_DONE` once busy reads low. `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `erase_seq`

## Requirements
- R1: The first byte of each frame is the opcode, sent most significant bit first: 8'h81 for page erase (`req_block`=0) and 8'h50 for block erase (`req_block`=1).
- R2: For page erase, the 24 address bits that follow the opcode are laid out as follows. In standard mode (`req_binary`=0) they are 2 zero bits, page[11:0], then 10 zero bits. In binary mode (`req_binary`=1) they are 3 zero bits, page[11:0], then 9 zero bits.
- R3: For block erase, the 24 address bits are laid out as follows. In standard mode they are 2 zero bits, page[11:3], then 13 zero bits. In binary mode they are 3 zero bits, page[11:3], then 12 zero bits.
- R4: While chip select is low there are exactly 32 rising SCK edges, and chip select rises after the 32nd bit.
- R5: `done` is asserted only after `busy_in` has been seen low, following the rise of chip select.
- R6: SCK is low whenever chip select is high, and MOSI is stable across every rising SCK edge.
- R7: In block erase, page bits [2:0] have no effect on the frame.
- R8: `req_ready` is low from the cycle after acceptance until `done`, and `done` lasts exactly one cycle.
- R9: Between frames, chip select stays high for at least `CS_GAP_SCK` SCK periods, that is, 2*`CS_GAP_SCK`*`HALF_DIV` system cycles.
- R10: After reset, chip select is high, SCK is low, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request is valid |
| req_ready | output | 1 | Sequencer is idle and can accept a request |
| req_block | input | 1 | 1 = block erase, 0 = page erase |
| req_binary | input | 1 | 1 = binary page-size mode, 0 = standard mode |
| req_page | input | 12 | Page number |
| done | output | 1 | One-cycle pulse when the erase has completed |
| busy_in | input | 1 | Flash busy indication, high while erasing |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
A corrupted shift register or bit counter is visible on the SPI wires within the same frame. The captured 32-bit word is wrong, or chip select rises after a number of edges other than 32. Both are checked the moment chip select rises. A state machine that skips the guard or wait states is exposed at the `done` pulse. That pulse would come early, while busy is still high or before the minimum chip-select high time, and the pulse is checked on the cycle it appears. A stuck `ST_DONE` or handshake state shows up within one cycle as a long `done` pulse or as ready being high during an operation.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
    localparam int PAGE_W  = 12;
    localparam int FRAME_W = 32;
    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_WAIT,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/erase_frame.sv
module erase_frame
    import erase_seq_pkg::*;
(
    input  logic               is_block,
    input  logic               is_binary,
    input  logic [PAGE_W-1:0]  page,
    output logic [FRAME_W-1:0] frame
);
    logic [23:0] addr;

    always_comb begin
        unique case ({is_block, is_binary})
            2'b00: addr = {2'b00,  page,       10'b0};
            2'b01: addr = {3'b000, page,       9'b0};
            2'b10: addr = {2'b00,  page[11:3], 13'b0};
            2'b11: addr = {3'b000, page[11:3], 12'b0};
            default: addr = '0;
        endcase
        frame = {(is_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE), addr};
    end
endmodule

// File: rtl/sck_divider.sv
module sck_divider #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int CS_GAP_SCK = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_block,
    input  logic        req_binary,
    input  logic [11:0] req_page,
    output logic        done,
    input  logic        busy_in,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi
);
    localparam int GAP_TICKS = 2 * CS_GAP_SCK;
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam int BW = $clog2(FRAME_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);
    localparam logic [GW-1:0] LAST_GAP = GW'(GAP_TICKS - 1);

    seq_state_e state_q, state_d;
    logic [FRAME_W-1:0] frame, shreg_q;
    logic [BW-1:0] bit_q;
    logic [GW-1:0] gap_q;
    logic sck_q, cs_q, tick;

    erase_frame u_frame (
        .is_block (req_block),
        .is_binary(req_binary),
        .page     (req_page),
        .frame    (frame)
    );

    sck_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q != ST_IDLE),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && sck_q && bit_q == LAST_BIT) state_d = ST_GAP;
            ST_GAP:   if (tick && gap_q == LAST_GAP) state_d = ST_WAIT;
            ST_WAIT:  if (!busy_in) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= '0;
            gap_q   <= '0;
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    shreg_q <= frame;
                    bit_q   <= '0;
                    sck_q   <= 1'b0;
                    cs_q    <= 1'b0;
                end
                ST_SHIFT: if (tick) begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q   <= 1'b0;
                        shreg_q <= shreg_q << 1;
                        if (bit_q == LAST_BIT) begin
                            cs_q  <= 1'b1;
                            gap_q <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_GAP: if (tick) gap_q <= gap_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign spi_cs_n  = cs_q;
    assign spi_sck   = sck_q;
    assign spi_mosi  = shreg_q[FRAME_W-1];

    // Independent edge counter used only by the assertions below
    logic [6:0] chk_edges_q;
    logic       chk_sck_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_edges_q <= '0;
            chk_sck_d   <= 1'b0;
        end else begin
            chk_sck_d <= spi_sck;
            if (spi_cs_n && !$past(spi_cs_n)) chk_edges_q <= chk_edges_q;
            if (!spi_cs_n && spi_sck && !chk_sck_d) chk_edges_q <= chk_edges_q + 1'b1;
            else if (done) chk_edges_q <= '0;
        end
    end

    assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> chk_edges_q == 7'd32);
    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    assert_busy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(busy_in) && spi_cs_n);
endmodule

// File: tb/tb_erase_seq.sv
module tb_erase_seq;
    localparam int HALF_DIV = 2;
    localparam int CS_GAP_SCK = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_block = 1'b0, req_binary = 1'b0;
    logic [11:0] req_page = '0;
    logic busy_in = 1'b0;
    logic req_ready, done, spi_cs_n, spi_sck, spi_mosi;

    int n_cmp = 0, n_bad = 0;

    erase_seq #(.HALF_DIV(HALF_DIV), .CS_GAP_SCK(CS_GAP_SCK)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_block(req_block), .req_binary(req_binary), .req_page(req_page),
        .done(done), .busy_in(busy_in), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi)
    );

    always #10 clk = ~clk;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          busy_len_q[$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input bit blk, input bit bin, input logic [11:0] pg, input int blen);
        logic [31:0] w;
        logic [23:0] a;
        if (!blk) a = bin ? (24'(pg) << 9) : (24'(pg) << 10);
        else      a = bin ? (24'(pg >> 3) << 12) : (24'(pg >> 3) << 13);
        w = {(blk ? 8'h50 : 8'h81), a};
        exp_q.push_back(w);
        tag_q.push_back(blk ? "R1/R3/R7 block frame" : "R1/R2 page frame");
        busy_len_q.push_back(blen);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_block = blk; req_binary = bin; req_page = pg;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: captures SPI frames, drives busy, checks timing
    logic [31:0] cap;
    int   nbits = 0, bcnt = 0, cs_high = 0;
    logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0, p_done = 1'b0;
    bit   released = 1'b1, inflight = 1'b0, framed = 1'b0;

    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n) begin
            check(!spi_sck, "R6 sck idle", spi_sck, 0);
        end
        if (!spi_cs_n && spi_sck && !p_sck) begin
            check(spi_mosi == p_mosi, "R6 mosi hold", spi_mosi, p_mosi);
            cap = {cap[30:0], spi_mosi};
            nbits++;
        end
        if (!spi_cs_n && p_cs) begin
            if (framed) check(cs_high >= 4 * CS_GAP_SCK * HALF_DIV / 2, "R9 cs gap", cs_high, 2 * CS_GAP_SCK * HALF_DIV);
            nbits = 0; cap = '0;
        end
        if (spi_cs_n) cs_high++; else cs_high = 0;
        if (spi_cs_n && !p_cs) begin
            framed = 1'b1;
            check(nbits == 32, "R4 bit count", nbits, 32);
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                int bl;
                e = exp_q.pop_front(); t = tag_q.pop_front(); bl = busy_len_q.pop_front();
                check(cap == e, t, cap, e);
                bcnt = bl; busy_in = (bl > 0); released = (bl == 0);
            end else check(0, "R1 unexpected frame", cap, 0);
        end else if (bcnt > 0) begin
            bcnt--;
            if (bcnt == 0) begin busy_in = 1'b0; released = 1'b1; end
        end
        if (inflight && !done) check(!req_ready, "R8 ready low", req_ready, 0);
        if (done) begin
            check(released && !busy_in, "R5 done after busy", busy_in, 0);
            check(!p_done, "R8 done width", p_done, 0);
            inflight = 1'b0;
        end
        if (req_valid && req_ready) inflight = 1'b1;
        p_cs = spi_cs_n; p_sck = spi_sck; p_mosi = spi_mosi; p_done = done;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sck && !done && req_ready, "R10 reset state",
              {spi_cs_n, spi_sck, done, req_ready}, 4'b1001);
        rst_n = 1'b1;
        send(0, 0, 12'hFFF, 5);
        send(0, 1, 12'hFFF, 0);
        send(0, 0, 12'h001, 3);
        send(0, 1, 12'h800, 40);
        send(1, 0, 12'hABF, 7);
        send(1, 0, 12'hAB8, 1);   // R7: same block as 0xABF
        send(1, 1, 12'h5A7, 0);
        send(1, 1, 12'h5A0, 12);  // R7
        send(0, 0, 12'h5A5, 2);
        while (inflight || exp_q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule